// File: doc/BRIEF.md
# Four-level nested interrupt controller

This block decides which of six interrupt sources an 8-bit CPU should take next. The sources are external input 0, timer 0, external input 1, timer 1, the serial port and timer 2. The CPU programs the block through a byte-wide special-function-register port. One register holds a master enable and one enable bit per source. Two more registers each hold one bit per source, and together these bits give every source one of four priority levels. When a request is permitted, the block raises `irq` with the source's vector address. It keeps that vector until the CPU acknowledges it.

The block keeps one in-service bit per priority level. A request is taken only when its level is strictly above every level in service, so a routine can be interrupted by higher levels up to three deep. A return-from-interrupt pulse retires the highest level in service, and the interrupted routine then carries on. On acknowledge the block sends a one-cycle clear strobe for the request flags that are cleared in hardware: the two timer overflow flags always, and an external flag only when that input is set up as edge-triggered.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the enable, high-priority and low-priority registers read 0, `irq` is low and `lvl_active` is 0.
- R2: A write at address A8h stores bit 7 (master enable) and bits 5..0 (per-source enables in the order timer 2, serial, timer 1, external 1, timer 0, external 0 from bit 5 down to bit 0). Bit 6 ignores writes and reads 0. Addresses B7h and B8h hold the 6-bit high and low priority fields, with the same source-to-bit map and bits 7..6 reading 0. Any other address reads 00h, and every read is combinational on `sfr_addr`.
- R3: While the master enable is 0, no new `irq` is raised, whatever the per-source bits and flags are.
- R4: A source requests only when its enable bit is 1. The serial request is `rx_flag | tx_flag`, and the timer 2 request is `t2ovf_flag | t2ext_flag`.
- R5: A source's level is {high bit, low bit}, from 0 (lowest) to 3 (highest). Among requesting sources, the one with the highest level wins.
- R6: Within one level, the winner is the first requester in the order external 0, timer 0, external 1, timer 1, serial, timer 2.
- R7: `irq_vec` is 03h + 8 x source index, where the index runs 0..5 in the order of R6 (03h, 0Bh, 13h, 1Bh, 23h, 2Bh).
- R8: `irq` rises on the clock edge after a permitted request is seen. While `irq` is high and `irq_ack` is low, `irq` and `irq_vec` stay unchanged. `irq` falls on the edge where `irq_ack` is sampled high.
- R9: A request is permitted only if its level is strictly greater than the highest set bit of `lvl_active`, or if `lvl_active` is 0. On acknowledge, bit [level] of `lvl_active` is set.
- R10: A `reti` pulse clears the highest set bit of `lvl_active` on the next edge.
- R11: On the cycle after an acknowledge, the matching clear strobe is high for one cycle. `clr_tmr0` and `clr_tmr1` pulse always. `clr_ext0` and `clr_ext1` pulse only if `ext0_edge` or `ext1_edge` was high at the acknowledge. Serial and timer 2 grants produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data |
| ext0_flag | input | 1 | External 0 request flag |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| ext1_flag | input | 1 | External 1 request flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| rx_flag | input | 1 | Serial receive flag |
| tx_flag | input | 1 | Serial transmit flag |
| t2ovf_flag | input | 1 | Timer 2 overflow flag |
| t2ext_flag | input | 1 | Timer 2 external flag |
| ext0_edge | input | 1 | External 0 is edge-triggered |
| ext1_edge | input | 1 | External 1 is edge-triggered |
| irq_ack | input | 1 | CPU accepts the pending interrupt |
| reti | input | 1 | Return-from-interrupt pulse |
| irq | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector address of the pending interrupt |
| lvl_active | output | 4 | In-service bit per priority level |
| clr_ext0 | output | 1 | Hardware clear strobe for external 0 flag |
| clr_tmr0 | output | 1 | Hardware clear strobe for timer 0 flag |
| clr_ext1 | output | 1 | Hardware clear strobe for external 1 flag |
| clr_tmr1 | output | 1 | Hardware clear strobe for timer 1 flag |

## Verification
Register reads are due in the same cycle as the address, and the value written appears right after the write edge. `irq` and `irq_vec` follow a flag change after one edge. `lvl_active` and the clear strobes change on the edge that samples `irq_ack` or `reti`. The bench drives inputs one time unit after the rising edge. It advances its reference model on each rising edge using the inputs settled before that edge, and it compares every output on the falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter logic [7:0] EN_ADDR = 8'hA8,
  parameter logic [7:0] HI_ADDR = 8'hB7,
  parameter logic [7:0] LO_ADDR = 8'hB8,
  parameter logic [7:0] VEC_BASE = 8'h03,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       ext0_flag,
  input  logic       tmr0_flag,
  input  logic       ext1_flag,
  input  logic       tmr1_flag,
  input  logic       rx_flag,
  input  logic       tx_flag,
  input  logic       t2ovf_flag,
  input  logic       t2ext_flag,
  input  logic       ext0_edge,
  input  logic       ext1_edge,
  input  logic       irq_ack,
  input  logic       reti,
  output logic       irq,
  output logic [7:0] irq_vec,
  output logic [3:0] lvl_active,
  output logic       clr_ext0,
  output logic       clr_tmr0,
  output logic       clr_ext1,
  output logic       clr_tmr1
);

  logic       ea;
  logic [5:0] en, hp, lp;
  logic [2:0] cur_src;
  logic [1:0] cur_lvl;

  logic [5:0] req;
  logic [2:0] win_src;
  logic [1:0] win_lvl;
  logic       win_ok;
  logic [1:0] ins_top;
  logic       grant_ok;
  logic       ack;
  logic [3:0] top_mask;

  assign req = {t2ovf_flag | t2ext_flag, rx_flag | tx_flag, tmr1_flag,
                ext1_flag, tmr0_flag, ext0_flag} & en & {6{ea}};

  always_comb begin
    win_ok  = 1'b0;
    win_src = '0;
    win_lvl = '0;
    for (int l = 0; l < 4; l++)
      for (int s = 5; s >= 0; s--)
        if (req[s] && {hp[s], lp[s]} == 2'(l)) begin
          win_ok  = 1'b1;
          win_src = 3'(s);
          win_lvl = 2'(l);
        end
  end

  always_comb begin
    ins_top = '0;
    for (int l = 0; l < 4; l++)
      if (lvl_active[l]) ins_top = 2'(l);
  end

  assign top_mask = (|lvl_active) ? (4'b0001 << ins_top) : 4'b0000;
  assign grant_ok = win_ok && (!(|lvl_active) || win_lvl > ins_top);
  assign ack      = irq && irq_ack;

  always_comb begin
    case (sfr_addr)
      EN_ADDR: sfr_rdata = {ea, 1'b0, en};
      HI_ADDR: sfr_rdata = {2'b00, hp};
      LO_ADDR: sfr_rdata = {2'b00, lp};
      default: sfr_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea <= 1'b0;
      en <= '0;
      hp <= '0;
      lp <= '0;
      irq <= 1'b0;
      irq_vec <= '0;
      cur_src <= '0;
      cur_lvl <= '0;
      lvl_active <= '0;
      {clr_ext0, clr_tmr0, clr_ext1, clr_tmr1} <= '0;
    end else begin
      if (sfr_wr) begin
        case (sfr_addr)
          EN_ADDR: begin ea <= sfr_wdata[7]; en <= sfr_wdata[5:0]; end
          HI_ADDR: hp <= sfr_wdata[5:0];
          LO_ADDR: lp <= sfr_wdata[5:0];
          default: ;
        endcase
      end
      if (ack) begin
        irq <= 1'b0;
      end else if (!irq && grant_ok) begin
        irq     <= 1'b1;
        cur_src <= win_src;
        cur_lvl <= win_lvl;
        irq_vec <= VEC_BASE + 8'(VEC_STEP) * {5'b0, win_src};
      end
      lvl_active <= (lvl_active & ~(reti ? top_mask : 4'b0000))
                  | (ack ? (4'b0001 << cur_lvl) : 4'b0000);
      clr_ext0 <= ack && cur_src == 3'd0 && ext0_edge;
      clr_tmr0 <= ack && cur_src == 3'd1;
      clr_ext1 <= ack && cur_src == 3'd2 && ext1_edge;
      clr_tmr1 <= ack && cur_src == 3'd3;
    end
  end

  a_r3_master_off_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!ea && !irq) |=> !irq);

  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> (irq && $stable(irq_vec)));

  a_r9_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(lvl_active) == 4'b0000 || cur_lvl > $past(ins_top)));

  a_r10_reti_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && lvl_active != 4'b0000) |=>
      ($countones(lvl_active) == $countones($past(lvl_active)) - 1));

  a_r11_strobe_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ext0 || clr_tmr0 || clr_ext1 || clr_tmr1) |-> $past(irq && irq_ack));

  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_ext0, clr_tmr0, clr_ext1, clr_tmr1}));

endmodule

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sfr_wr = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic ext0_flag = 0, tmr0_flag = 0, ext1_flag = 0, tmr1_flag = 0;
  logic rx_flag = 0, tx_flag = 0, t2ovf_flag = 0, t2ext_flag = 0;
  logic ext0_edge = 0, ext1_edge = 0, irq_ack = 0, reti = 0;
  logic irq;
  logic [7:0] irq_vec;
  logic [3:0] lvl_active;
  logic clr_ext0, clr_tmr0, clr_ext1, clr_tmr1;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irq_nest_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .ext0_flag(ext0_flag), .tmr0_flag(tmr0_flag), .ext1_flag(ext1_flag),
    .tmr1_flag(tmr1_flag), .rx_flag(rx_flag), .tx_flag(tx_flag),
    .t2ovf_flag(t2ovf_flag), .t2ext_flag(t2ext_flag),
    .ext0_edge(ext0_edge), .ext1_edge(ext1_edge), .irq_ack(irq_ack),
    .reti(reti), .irq(irq), .irq_vec(irq_vec), .lvl_active(lvl_active),
    .clr_ext0(clr_ext0), .clr_tmr0(clr_tmr0), .clr_ext1(clr_ext1),
    .clr_tmr1(clr_tmr1));

  // behavioural reference
  bit       m_ea;
  bit [5:0] m_en, m_hp, m_lp;
  bit       m_irq;
  int       m_src, m_lvl;
  bit [7:0] m_vec;
  bit [3:0] m_ins;
  bit [3:0] m_clr;

  always @(posedge clk) begin
    bit [5:0] r;
    int best, bl, top;
    bit acked;
    if (!rst_n) begin
      m_ea = 0; m_en = 0; m_hp = 0; m_lp = 0; m_irq = 0;
      m_src = 0; m_lvl = 0; m_vec = 0; m_ins = 0; m_clr = 0;
    end else begin
      r = {t2ovf_flag | t2ext_flag, rx_flag | tx_flag, tmr1_flag, ext1_flag, tmr0_flag, ext0_flag};
      best = -1; bl = -1;
      for (int lv = 3; lv >= 0; lv--)
        for (int s = 0; s < 6; s++)
          if (best < 0 && m_ea && m_en[s] && r[s] && (2 * m_hp[s] + m_lp[s]) == lv) begin
            best = s; bl = lv;
          end
      top = -1;
      for (int l = 0; l < 4; l++) if (m_ins[l]) top = l;
      acked = m_irq && irq_ack;
      m_clr = 0;
      if (reti && top >= 0) m_ins[top] = 0;
      if (acked) begin
        m_ins[m_lvl] = 1;
        m_irq = 0;
        if (m_src == 0) m_clr[0] = ext0_edge;
        if (m_src == 1) m_clr[1] = 1;
        if (m_src == 2) m_clr[2] = ext1_edge;
        if (m_src == 3) m_clr[3] = 1;
      end else if (!m_irq && best >= 0 && bl > top) begin
        m_irq = 1; m_src = best; m_lvl = bl; m_vec = 8'(3 + 8 * best);
      end
      if (sfr_wr) begin
        if (sfr_addr == 8'hA8) begin m_ea = sfr_wdata[7]; m_en = sfr_wdata[5:0]; end
        if (sfr_addr == 8'hB7) m_hp = sfr_wdata[5:0];
        if (sfr_addr == 8'hB8) m_lp = sfr_wdata[5:0];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit [7:0] rexp;
    if (rst_n) begin
      case (sfr_addr)
        8'hA8: rexp = {m_ea, 1'b0, m_en};
        8'hB7: rexp = {2'b00, m_hp};
        8'hB8: rexp = {2'b00, m_lp};
        default: rexp = 8'h00;
      endcase
      chk("R2 sfr_rdata", 32'(sfr_rdata), 32'(rexp));
      chk("R8 irq", 32'(irq), 32'(m_irq));
      if (m_irq) chk("R7 irq_vec", 32'(irq_vec), 32'(m_vec));
      chk("R9 lvl_active", 32'(lvl_active), 32'(m_ins));
      chk("R11 clear strobes", 32'({clr_tmr1, clr_ext1, clr_tmr0, clr_ext0}), 32'(m_clr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
    cyc(1);
    sfr_wr = 0;
  endtask

  task automatic take();
    irq_ack = 1; cyc(1); irq_ack = 0;
  endtask

  task automatic ret();
    reti = 1; cyc(1); reti = 0;
  endtask

  task automatic flags_off();
    {ext0_flag, tmr0_flag, ext1_flag, tmr1_flag, rx_flag, tx_flag, t2ovf_flag, t2ext_flag} = '0;
  endtask

  task automatic raise(input int s);
    case (s)
      0: ext0_flag = 1;
      1: tmr0_flag = 1;
      2: ext1_flag = 1;
      3: tmr1_flag = 1;
      4: tx_flag = 1;
      default: t2ovf_flag = 1;
    endcase
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    sfr_addr = 8'hA8; #1;
    chk("R1 enable reg after reset", 32'(sfr_rdata), 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 lvl_active after reset", 32'(lvl_active), 32'h0);
    sfr_addr = 8'hB7; #1;
    chk("R1 high reg after reset", 32'(sfr_rdata), 32'h0);

    wr(8'hA8, 8'hFF);
    sfr_addr = 8'hA8; #1;
    chk("R2 reserved bit reads 0", 32'(sfr_rdata), 32'hBF);
    wr(8'hB7, 8'hFF);
    sfr_addr = 8'hB7; #1;
    chk("R2 high field width", 32'(sfr_rdata), 32'h3F);
    wr(8'hB7, 8'h00);
    sfr_addr = 8'h55; #1;
    chk("R2 unmapped reads 0", 32'(sfr_rdata), 32'h0);

    // R3: master enable off
    wr(8'hA8, 8'h3F);
    {ext0_flag, tmr0_flag, ext1_flag, tmr1_flag, rx_flag, t2ovf_flag} = '1;
    cyc(3);
    chk("R3 master off blocks", 32'(irq), 32'h0);
    flags_off();

    // R7/R11: each source alone
    for (int s = 0; s < 6; s++) begin
      wr(8'hA8, 8'h80 | 8'(1 << s));
      ext0_edge = (s == 0); ext1_edge = 0;
      raise(s);
      cyc(2);
      chk("R7 per-source vector", 32'(irq_vec), 32'(3 + 8 * s));
      take();
      chk("R11 strobe pattern", 32'({clr_tmr1, clr_ext1, clr_tmr0, clr_ext0}),
          (s == 0) ? 32'h1 : (s == 1) ? 32'h2 : (s == 3) ? 32'h8 : 32'h0);
      flags_off();
      ret();
      chk("R10 reti empties level 0", 32'(lvl_active), 32'h0);
    end

    // R4: disabled source blocked, ORed flags
    wr(8'hA8, 8'h90);
    t2ext_flag = 1;
    cyc(3);
    chk("R4 disabled timer2 blocked", 32'(irq), 32'h0);
    rx_flag = 1;
    cyc(2);
    chk("R4 receive flag requests serial", 32'(irq_vec), 32'h23);
    take(); flags_off(); ret();
    wr(8'hA8, 8'hA0);
    t2ext_flag = 1;
    cyc(2);
    chk("R4 timer2 external flag requests", 32'(irq_vec), 32'h2B);
    take(); flags_off(); ret();

    // R6 polling order, R8 hold
    wr(8'hA8, 8'hBF);
    {ext1_flag, tmr1_flag, rx_flag, t2ovf_flag} = '1;
    cyc(2);
    chk("R6 tie goes to external 1", 32'(irq_vec), 32'h13);
    ext0_flag = 1;
    cyc(3);
    chk("R8 vector held until ack", 32'(irq_vec), 32'h13);
    take(); flags_off(); ret();

    // R5 and R9 nesting
    wr(8'hB7, 8'h08);
    wr(8'hB8, 8'h01);
    ext0_edge = 1;
    {ext0_flag, tmr1_flag} = '1;
    cyc(2);
    chk("R5 level 2 beats level 1", 32'(irq_vec), 32'h1B);
    take();
    tmr1_flag = 0;
    cyc(3);
    chk("R9 lower level waits", 32'(irq), 32'h0);
    chk("R9 level 2 in service", 32'(lvl_active), 32'h4);
    wr(8'hB7, 8'h28);
    wr(8'hB8, 8'h21);
    t2ovf_flag = 1;
    cyc(2);
    chk("R9 level 3 preempts", 32'(irq_vec), 32'h2B);
    take();
    t2ovf_flag = 0;
    cyc(1);
    chk("R9 two levels in service", 32'(lvl_active), 32'hC);
    ret();
    chk("R10 highest level retired", 32'(lvl_active), 32'h4);
    ret();
    cyc(1);
    chk("R9 resumed level 1 request", 32'(irq_vec), 32'h03);
    take();
    chk("R11 edge-mode external 0 cleared", 32'(clr_ext0), 32'h1);
    ext0_flag = 0;
    wr(8'hB8, 8'h25);
    ext1_flag = 1;
    cyc(3);
    chk("R9 equal level waits", 32'(irq), 32'h0);
    ret();
    cyc(1);
    chk("R9 equal level after return", 32'(irq_vec), 32'h13);
    take(); flags_off(); ret();
    cyc(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule